// File: doc/BRIEF.md
# UART Debug Bus Bridge

This block lets a host on a serial link act as a master on a simple on-chip memory bus. Bytes come from a UART receiver over a valid/ready handshake. The block picks out framed commands from that stream and turns each command into one 32-bit word access on the bus. For a read, the word that comes back is sent to a UART transmitter as a short byte sequence over a second valid/ready handshake.

A frame starts with a command byte. The write command is followed by four address bytes and then four data bytes. The read command is followed only by four address bytes. Both fields are sent with the most significant byte first. A synchronisation byte, and any other byte that does not start a frame, is accepted and dropped while the parser is idle. Every access is word aligned, because the two lowest address bits are always driven as zero.

Top module: `uart_bus_bridge`

## Requirements
- R1: After a synchronous reset, `bus_req` and `tx_valid` are 0 and `rx_ready` is 1.
- R2: The byte 0x55 received while idle is accepted (`rx_ready`=1), starts no bus request, and the next byte is still parsed as a command byte.
- R3: While idle, any byte other than 0x80 or 0xC0 is accepted and discarded. The parser stays idle and raises no request.
- R4: Command byte 0xC0 followed by 4 address bytes and 4 data bytes produces exactly one request with `bus_we`=1.
- R5: Command byte 0x80 followed by 4 address bytes produces exactly one request with `bus_we`=0. No data bytes are taken.
- R6: Address bytes fill the address from bits 31:24 down to bits 7:0 in arrival order. Bytes of value 0x55, 0x80 or 0xC0 inside a frame count as field bytes.
- R7: Write data bytes fill `bus_wdata` from bits 31:24 down to bits 7:0 in arrival order.
- R8: `bus_addr[1:0]` is 0 whatever the last address byte holds.
- R9: `bus_req` rises only in the cycle after the last byte of the frame is accepted. It stays high, with address, data and write enable unchanged, until a cycle in which `bus_ack` is 1.
- R10: For a read, the word on `bus_rdata` in the acknowledge cycle is returned as 4 bytes, bits 31:24 first and bits 7:0 last. Each byte is sent on one `tx_valid`/`tx_ready` handshake and is held stable while `tx_ready` is low.
- R11: From the read acknowledge until the fourth response byte is taken, `rx_ready` is 0. Afterwards it returns to 1.
- R12: A reset during a frame or during a pending request returns the parser to idle, clears the byte count and drops `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block takes the received byte this cycle |
| tx_valid | output | 1 | Response byte available |
| tx_data | output | 8 | Response byte |
| tx_ready | input | 1 | Transmitter takes the response byte |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, sampled with acknowledge |
| bus_ack | input | 1 | Bus completes the access |

## Verification
The hardest situations to reach from the ports are the ones where the frame position and the byte value disagree. Examples are a command code or a sync byte sitting inside an address or data field, or a reset arriving after only part of a frame. A read issued right after such a reset exposes any stale byte count, because the bytes would then be parsed under the wrong frame. The vector table places 0x55, 0x80 and 0xC0 at several field positions and sets the low address bits to nonzero values. Directed tests interrupt a write frame and a pending read with reset, and then issue clean commands. Both the bus acknowledge and the transmitter ready are stalled for varying numbers of cycles to exercise the hold rules.

// File: rtl/ubb_pkg.sv
package ubb_pkg;
  localparam int WORD_W = 32;
  localparam int OCTET_W = 8;

  localparam logic [7:0] OP_WRITE = 8'hC0;
  localparam logic [7:0] OP_READ  = 8'h80;
  localparam logic [7:0] OP_SYNC  = 8'h55;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_DATA = 3'd2,
    PH_BUS  = 3'd3,
    PH_RESP = 3'd4
  } phase_t;
endpackage

// File: rtl/ubb_shreg.sv
module ubb_shreg #(
  parameter int W  = ubb_pkg::WORD_W,
  parameter int BW = ubb_pkg::OCTET_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic [BW-1:0] octet,
  output logic [W-1:0]  word
);
  function automatic logic [W-1:0] push_low(input logic [W-1:0] cur, input logic [BW-1:0] b);
    return {cur[W-BW-1:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else if (shift_en) word <= push_low(word, octet);
  end
endmodule

// File: rtl/ubb_ctrl.sv
module ubb_ctrl #(
  parameter int NBYTES = ubb_pkg::WORD_W / ubb_pkg::OCTET_W,
  parameter int BW     = ubb_pkg::OCTET_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [BW-1:0] rx_data,
  output logic          rx_ready,
  output logic          addr_shift,
  output logic          data_shift,
  output logic          bus_req,
  output logic          bus_we,
  input  logic          bus_ack,
  output logic          resp_active,
  input  logic          resp_done,
  output logic          cmd_idle
);
  import ubb_pkg::*;
  localparam int CNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             is_wr;
  logic             rx_fire, last_byte;

  assign rx_ready    = (phase == PH_IDLE) || (phase == PH_ADDR) || (phase == PH_DATA);
  assign rx_fire     = rx_valid && rx_ready;
  assign last_byte   = (cnt == LAST);
  assign addr_shift  = rx_fire && (phase == PH_ADDR);
  assign data_shift  = rx_fire && (phase == PH_DATA);
  assign bus_req     = (phase == PH_BUS);
  assign bus_we      = is_wr;
  assign resp_active = (phase == PH_RESP);
  assign cmd_idle    = (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      is_wr <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (rx_fire) begin
          cnt <= '0;
          if (rx_data == OP_WRITE) begin
            is_wr <= 1'b1;
            phase <= PH_ADDR;
          end else if (rx_data == OP_READ) begin
            is_wr <= 1'b0;
            phase <= PH_ADDR;
          end
        end
        PH_ADDR: if (rx_fire) begin
          if (last_byte) begin
            cnt   <= '0;
            phase <= is_wr ? PH_DATA : PH_BUS;
          end else cnt <= cnt + 1'b1;
        end
        PH_DATA: if (rx_fire) begin
          if (last_byte) begin
            cnt   <= '0;
            phase <= PH_BUS;
          end else cnt <= cnt + 1'b1;
        end
        PH_BUS:  if (bus_ack) phase <= is_wr ? PH_IDLE : PH_RESP;
        PH_RESP: if (resp_done) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ubb_txseq.sv
module ubb_txseq #(
  parameter int W  = ubb_pkg::WORD_W,
  parameter int BW = ubb_pkg::OCTET_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  word_in,
  input  logic          active,
  input  logic          tx_ready,
  output logic [BW-1:0] tx_data,
  output logic          done
);
  localparam int NBYTES = W / BW;
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  logic [W-1:0]     word_q;
  logic [CNT_W-1:0] cnt;
  logic             fire;

  function automatic logic [W-1:0] drop_high(input logic [W-1:0] cur);
    return {cur[W-BW-1:0], {BW{1'b0}}};
  endfunction

  assign fire    = active && tx_ready;
  assign done    = fire && (cnt == LAST);
  assign tx_data = word_q[W-1 -: BW];

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      cnt    <= '0;
    end else if (load) begin
      word_q <= word_in;
      cnt    <= '0;
    end else if (fire) begin
      word_q <= drop_high(word_q);
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_bus_bridge.sv
module uart_bus_bridge #(
  parameter int DATA_W = ubb_pkg::WORD_W,
  parameter int BYTE_W = ubb_pkg::OCTET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              bus_req,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int LANE_B = $clog2(NBYTES);

  logic              addr_shift, data_shift, resp_done, cmd_idle, rd_load;
  logic [DATA_W-1:0] addr_raw;

  function automatic logic [DATA_W-1:0] word_align(input logic [DATA_W-1:0] a);
    return {a[DATA_W-1:LANE_B], {LANE_B{1'b0}}};
  endfunction

  ubb_ctrl #(.NBYTES(NBYTES), .BW(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .addr_shift(addr_shift), .data_shift(data_shift), .bus_req(bus_req), .bus_we(bus_we),
    .bus_ack(bus_ack), .resp_active(tx_valid), .resp_done(resp_done), .cmd_idle(cmd_idle)
  );

  ubb_shreg #(.W(DATA_W), .BW(BYTE_W)) u_addr (
    .clk(clk), .rst(rst), .shift_en(addr_shift), .octet(rx_data), .word(addr_raw)
  );

  ubb_shreg #(.W(DATA_W), .BW(BYTE_W)) u_wdata (
    .clk(clk), .rst(rst), .shift_en(data_shift), .octet(rx_data), .word(bus_wdata)
  );

  assign rd_load  = bus_req && bus_ack && !bus_we;
  assign bus_addr = word_align(addr_raw);

  ubb_txseq #(.W(DATA_W), .BW(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .load(rd_load), .word_in(bus_rdata), .active(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .done(resp_done)
  );
endmodule

// File: rtl/ubb_checker.sv
module ubb_checker #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_ready,
  input logic              bus_req,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              cmd_idle
);
  p_reset_quiet_r1: assert property (@(posedge clk) $past(rst) |-> !bus_req && !tx_valid && rx_ready);

  p_sync_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_idle && rx_valid && rx_data == 8'h55 |=> cmd_idle && !bus_req);

  p_req_after_byte_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(rx_valid && rx_ready));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we));

  p_tx_hold_r10: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  p_read_resp_r10: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack && !bus_we |=> tx_valid);

  p_no_rx_in_resp_r11: assert property (@(posedge clk) disable iff (rst)
    !(tx_valid && rx_ready) && !(bus_req && rx_ready));
endmodule

bind uart_bus_bridge ubb_checker #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ubb_checker (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .cmd_idle(cmd_idle)
);

// File: tb/tb_uart_bus_bridge.sv
module tb_uart_bus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // entry: {is_write, address, data}
  localparam logic [64:0] VEC [NVEC] = '{
    {1'b1, 32'h1234_5678, 32'hDEAD_BEEF},
    {1'b0, 32'h0000_1003, 32'h0},
    {1'b1, 32'h55C0_8055, 32'h8055_C055},
    {1'b0, 32'hC055_8002, 32'h0},
    {1'b1, 32'hFFFF_FFFF, 32'h0000_0001},
    {1'b0, 32'h8000_0001, 32'h0}
  };

  logic clk = 0, rst = 1;
  logic rx_valid = 0, tx_ready = 0, bus_ack = 0;
  logic [7:0] rx_data = 0;
  logic [31:0] bus_rdata = 0;
  logic rx_ready, tx_valid, bus_req, bus_we;
  logic [7:0] tx_data;
  logic [31:0] bus_addr, bus_wdata;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_bus_bridge dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack)
  );

  function automatic logic [31:0] mem_model(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hA5C3_0F96;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic send_word(input logic [31:0] w, input bit last_field);
    for (int k = 3; k >= 0; k--) begin
      if (last_field && k == 0) check("R9 no early request", 32'(bus_req), 32'd0);
      send_byte(w[k*8 +: 8]);
    end
  endtask

  task automatic serve(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                       input logic [31:0] rd, input int stall);
    int n = 0;
    while (!bus_req && n < 50) begin @(negedge clk); n++; end
    check("R9 request raised after last byte", 32'(n), 32'd0);
    check(we ? "R4 write enable" : "R5 read enable", 32'(bus_we), 32'(we));
    check("R6/R8 address", bus_addr, {addr[31:2], 2'b00});
    if (we) check("R7 write data", bus_wdata, wd);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check("R9 request held", 32'(bus_req), 32'd1);
      check("R9 address stable", bus_addr, {addr[31:2], 2'b00});
    end
    bus_ack = 1;
    bus_rdata = rd;
    @(negedge clk);
    bus_ack = 0;
    bus_rdata = 32'h0;
    check("R4/R5 single request", 32'(bus_req), 32'd0);
  endtask

  task automatic recv_word(input logic [31:0] exp, input int stall);
    for (int k = 3; k >= 0; k--) begin
      check("R11 no intake during response", 32'(rx_ready), 32'd0);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check("R10 byte held while stalled", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, exp[k*8 +: 8]});
      end
      check("R10 response byte", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, exp[k*8 +: 8]});
      tx_ready = 1;
      @(negedge clk);
      tx_ready = 0;
    end
    check("R10 response ends after 4 bytes", 32'(tx_valid), 32'd0);
    check("R11 intake resumes", 32'(rx_ready), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 bus_req", 32'(bus_req), 32'd0);
    check("R1 tx_valid", 32'(tx_valid), 32'd0);
    check("R1 rx_ready", 32'(rx_ready), 32'd1);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      logic        w;
      logic [31:0] a, d;
      {w, a, d} = VEC[i];
      send_byte(w ? 8'hC0 : 8'h80);
      send_word(a, !w);
      if (w) send_word(d, 1'b1);
      serve(w, a, d, mem_model({a[31:2], 2'b00}), i % 3);
      if (w) check("R4 back to idle", 32'(rx_ready), 32'd1);
      else   recv_word(mem_model({a[31:2], 2'b00}), i % 2);
    end

    // R2: sync bytes ignored, next byte still a command
    send_byte(8'h55);
    send_byte(8'h55);
    repeat (3) @(negedge clk);
    check("R2 sync starts nothing", {30'd0, bus_req, rx_ready}, 32'd1);
    send_byte(8'h80);
    send_word(32'h0000_2468, 1'b1);
    serve(1'b0, 32'h0000_2468, 32'h0, 32'h0102_0304, 0);
    recv_word(32'h0102_0304, 0);

    // R3: stray bytes discarded
    send_byte(8'h12);
    send_byte(8'hFF);
    send_byte(8'h00);
    send_byte(8'h81);
    repeat (3) @(negedge clk);
    check("R3 stray bytes start nothing", {30'd0, bus_req, rx_ready}, 32'd1);
    send_byte(8'hC0);
    send_word(32'h0000_0100, 1'b0);
    send_word(32'h0BAD_F00D, 1'b1);
    serve(1'b1, 32'h0000_0100, 32'h0BAD_F00D, 32'h0, 1);

    // R12: reset in the middle of a write frame
    send_byte(8'hC0);
    send_byte(8'h11);
    send_byte(8'h22);
    do_reset();
    check("R12 idle after mid-frame reset", {30'd0, bus_req, rx_ready}, 32'd1);
    send_byte(8'h80);
    send_word(32'hCAFE_0007, 1'b1);
    serve(1'b0, 32'hCAFE_0007, 32'h0, 32'h5566_7788, 0);
    recv_word(32'h5566_7788, 1);

    // R12: reset while a request is pending
    send_byte(8'h80);
    send_word(32'h0000_0040, 1'b1);
    @(negedge clk);
    check("R12 request pending before reset", 32'(bus_req), 32'd1);
    do_reset();
    check("R12 request dropped", {29'd0, bus_req, tx_valid, rx_ready}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule